// File: doc/BRIEF.md
# Multi-Exception Priority Resolver

This block chooses the one exception to take when a single indivisible operation raises several exception conditions in the same step. The order is not a fixed ranking of causes: it depends on how the operation is built. In two-transfer mode one instruction makes two memory data transfers, as in multiply-accumulate, memory-to-memory arithmetic or logic, and atomic test-and-set. Here every fault of the first transfer outranks every fault of the second. In branch/slot mode a delayed branch and its delay-slot instruction are resolved as one unit. The level 1–2 interrupt-type and re-execution-type checks of both instructions come before the completion-type checks of either. The level 3 and level 4 steps each cover both instructions together.

The condition flags arrive as vectors grouped by source, priority level and exception type, together with a mode select and a flag that says whether the slot instruction makes a second transfer. The selection logic is combinational. On the clock edge where the request strobe is high, it loads a registered result: a valid bit, a 6-bit cause code, a source bit (branch or slot) and a transfer index. Exception vector generation and pipeline flushing are outside this block.

Top module: `exc_prio_resolver`

## Requirements
- R1: A synchronous active-high `rst` clears `out_valid`, `out_cause`, `out_src` and `out_xfer` to zero on the next clock edge.
- R2: The outputs load only on a clock edge where `req` is high. On any other edge they hold their value, whatever the flag inputs do.
- R3: The cause code is {group, index}: group is bits 5:3 and index is bits 2:0. The groups are: memory fault = 0, level 1–2 interrupt/re-execution = 1, level 2 completion = 2, level 3 = 3, level 4 = 4. The index is the bit position of the winning flag, and within one vector the lowest set bit wins. The memory fault bits are: 0 data address error, 1 translation miss, 2 translation protection violation, 3 initial-page-write fault.
- R4: In two-transfer mode (`mode`=0), any set bit of `xfer0_flt` beats any set bit of `xfer1_flt`. `out_src` is 0, and all other flag vectors and `slot_two_xfer` have no effect.
- R5: In branch/slot mode (`mode`=1) the steps are checked in this order: `br_l12`; `xfer0_flt` (slot, transfer 0); `xfer1_flt` (slot, transfer 1, only when `slot_two_xfer`=1); `sl_l12`; `br_c2`; `sl_c2`; the level 3 step; the level 4 step. `out_src` is 0 for branch vectors and 1 for slot vectors.
- R6: When the level 3 step (`br_l3`, `sl_l3`) or the level 4 step (`br_l4`, `sl_l4`) has flags from both instructions, the branch is reported as the source.
- R7: In branch/slot mode with `slot_two_xfer`=0, `xfer1_flt` has no effect.
- R8: A request with no flag that counts in the current mode loads `out_valid`=0 and zero on every other output.
- R9: `out_xfer` is 1 only when the winner comes from `xfer1_flt`. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe; result is loaded on this edge |
| mode | input | 1 | 0 = two-transfer, 1 = branch/slot |
| slot_two_xfer | input | 1 | Slot instruction makes a second data transfer |
| xfer0_flt | input | 4 | Memory faults of transfer 0 |
| xfer1_flt | input | 4 | Memory faults of transfer 1 |
| br_l12 | input | NGEN | Branch level 1–2 interrupt/re-execution flags |
| sl_l12 | input | NGEN | Slot level 1–2 interrupt/re-execution flags |
| br_c2 | input | NGEN | Branch level 2 completion flags |
| sl_c2 | input | NGEN | Slot level 2 completion flags |
| br_l3 | input | NGEN | Branch level 3 flags |
| sl_l3 | input | NGEN | Slot level 3 flags |
| br_l4 | input | NGEN | Branch level 4 flags |
| sl_l4 | input | NGEN | Slot level 4 flags |
| out_valid | output | 1 | An exception was selected |
| out_cause | output | 6 | Cause code {group, index} |
| out_src | output | 1 | 0 = branch, 1 = slot |
| out_xfer | output | 1 | Transfer index of a memory fault winner |

## Verification
The hardest cases to reach are those where many steps are active at once and only the ordering between them decides the answer. Examples are a slot transfer-1 fault competing with slot level 1–2 flags while `slot_two_xfer` toggles, and a level 3 step where branch and slot flags are both set. The stimulus covers these by sweeping every subset of the ten branch/slot flag vectors under both settings of `slot_two_xfer`. Each active vector gets a nonzero pattern that changes from subset to subset. Two-transfer mode is swept over every pair of transfer fault vectors, with the other inputs filled with noise to show they have no effect.

// File: rtl/exc_res_pkg.sv
package exc_res_pkg;

    localparam int MEM_FLT_W = 4;
    localparam int GRP_W     = 3;
    localparam int IDX_W     = 3;
    localparam int CODE_W    = GRP_W + IDX_W;
    localparam int NUM_GEN   = 8;

    // Order of the generic flag vectors inside the resolver
    localparam int G_BR_L12 = 0;
    localparam int G_SL_L12 = 1;
    localparam int G_BR_C2  = 2;
    localparam int G_SL_C2  = 3;
    localparam int G_BR_L3  = 4;
    localparam int G_SL_L3  = 5;
    localparam int G_BR_L4  = 6;
    localparam int G_SL_L4  = 7;

    typedef enum logic [GRP_W-1:0] {
        GRP_MEM = 3'd0,
        GRP_L12 = 3'd1,
        GRP_C2  = 3'd2,
        GRP_L3  = 3'd3,
        GRP_L4  = 3'd4
    } grp_e;

    localparam logic SRC_BR   = 1'b0;
    localparam logic SRC_SLOT = 1'b1;

    typedef struct packed {
        logic              hit;
        logic [IDX_W-1:0]  idx;
    } cand_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] cause;
        logic              src;
        logic              xfer;
    } res_t;

    function automatic res_t make_res(grp_e g, logic [IDX_W-1:0] i, logic s, logic x);
        res_t r;
        r.valid = 1'b1;
        r.cause = {g, i};
        r.src   = s;
        r.xfer  = x;
        return r;
    endfunction

endpackage

// File: rtl/exc_first_set.sv
module exc_first_set
    import exc_res_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] flags,
    output cand_t        cand
);
    always_comb begin
        cand = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (flags[i]) begin
                cand.hit = 1'b1;
                cand.idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/exc_order_select.sv
module exc_order_select
    import exc_res_pkg::*;
(
    input  logic                 mode,
    input  logic                 slot_two_xfer,
    input  cand_t [1:0]          mem_c,
    input  cand_t [NUM_GEN-1:0]  gen_c,
    output res_t                 res
);
    always_comb begin
        res = '0;
        if (!mode) begin
            if (mem_c[0].hit)
                res = make_res(GRP_MEM, mem_c[0].idx, SRC_BR, 1'b0);
            else if (mem_c[1].hit)
                res = make_res(GRP_MEM, mem_c[1].idx, SRC_BR, 1'b1);
        end else begin
            if (gen_c[G_BR_L12].hit)
                res = make_res(GRP_L12, gen_c[G_BR_L12].idx, SRC_BR, 1'b0);
            else if (mem_c[0].hit)
                res = make_res(GRP_MEM, mem_c[0].idx, SRC_SLOT, 1'b0);
            else if (slot_two_xfer && mem_c[1].hit)
                res = make_res(GRP_MEM, mem_c[1].idx, SRC_SLOT, 1'b1);
            else if (gen_c[G_SL_L12].hit)
                res = make_res(GRP_L12, gen_c[G_SL_L12].idx, SRC_SLOT, 1'b0);
            else if (gen_c[G_BR_C2].hit)
                res = make_res(GRP_C2, gen_c[G_BR_C2].idx, SRC_BR, 1'b0);
            else if (gen_c[G_SL_C2].hit)
                res = make_res(GRP_C2, gen_c[G_SL_C2].idx, SRC_SLOT, 1'b0);
            else if (gen_c[G_BR_L3].hit)
                res = make_res(GRP_L3, gen_c[G_BR_L3].idx, SRC_BR, 1'b0);
            else if (gen_c[G_SL_L3].hit)
                res = make_res(GRP_L3, gen_c[G_SL_L3].idx, SRC_SLOT, 1'b0);
            else if (gen_c[G_BR_L4].hit)
                res = make_res(GRP_L4, gen_c[G_BR_L4].idx, SRC_BR, 1'b0);
            else if (gen_c[G_SL_L4].hit)
                res = make_res(GRP_L4, gen_c[G_SL_L4].idx, SRC_SLOT, 1'b0);
        end
    end
endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
    import exc_res_pkg::*;
#(
    parameter int NGEN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req,
    input  logic                 mode,
    input  logic                 slot_two_xfer,
    input  logic [MEM_FLT_W-1:0] xfer0_flt,
    input  logic [MEM_FLT_W-1:0] xfer1_flt,
    input  logic [NGEN-1:0]      br_l12,
    input  logic [NGEN-1:0]      sl_l12,
    input  logic [NGEN-1:0]      br_c2,
    input  logic [NGEN-1:0]      sl_c2,
    input  logic [NGEN-1:0]      br_l3,
    input  logic [NGEN-1:0]      sl_l3,
    input  logic [NGEN-1:0]      br_l4,
    input  logic [NGEN-1:0]      sl_l4,
    output logic                 out_valid,
    output logic [CODE_W-1:0]    out_cause,
    output logic                 out_src,
    output logic                 out_xfer
);
    logic [NGEN-1:0]      gvec [NUM_GEN];
    logic [MEM_FLT_W-1:0] mvec [2];
    cand_t [NUM_GEN-1:0]  gen_c;
    cand_t [1:0]          mem_c;
    res_t                 res_d, res_q;

    assign gvec[G_BR_L12] = br_l12;
    assign gvec[G_SL_L12] = sl_l12;
    assign gvec[G_BR_C2]  = br_c2;
    assign gvec[G_SL_C2]  = sl_c2;
    assign gvec[G_BR_L3]  = br_l3;
    assign gvec[G_SL_L3]  = sl_l3;
    assign gvec[G_BR_L4]  = br_l4;
    assign gvec[G_SL_L4]  = sl_l4;
    assign mvec[0]        = xfer0_flt;
    assign mvec[1]        = xfer1_flt;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_pick
        exc_first_set #(.W(NGEN)) u_pick (
            .flags (gvec[g]),
            .cand  (gen_c[g])
        );
    end

    for (genvar t = 0; t < 2; t++) begin : g_mem_pick
        exc_first_set #(.W(MEM_FLT_W)) u_pick (
            .flags (mvec[t]),
            .cand  (mem_c[t])
        );
    end

    exc_order_select u_sel (
        .mode          (mode),
        .slot_two_xfer (slot_two_xfer),
        .mem_c         (mem_c),
        .gen_c         (gen_c),
        .res           (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (req)
            res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_cause = res_q.cause;
    assign out_src   = res_q.src;
    assign out_xfer  = res_q.xfer;
endmodule

// File: rtl/exc_prio_resolver_chk.sv
module exc_prio_resolver_chk
    import exc_res_pkg::*;
#(
    parameter int NGEN = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req,
    input logic                 mode,
    input logic                 slot_two_xfer,
    input logic [MEM_FLT_W-1:0] xfer0_flt,
    input logic [MEM_FLT_W-1:0] xfer1_flt,
    input logic [NGEN-1:0]      br_l12,
    input logic [NGEN-1:0]      sl_l12,
    input logic [NGEN-1:0]      br_c2,
    input logic [NGEN-1:0]      sl_c2,
    input logic [NGEN-1:0]      br_l3,
    input logic [NGEN-1:0]      sl_l3,
    input logic [NGEN-1:0]      br_l4,
    input logic [NGEN-1:0]      sl_l4,
    input logic                 out_valid,
    input logic [CODE_W-1:0]    out_cause,
    input logic                 out_src,
    input logic                 out_xfer
);
    logic any_gen;
    assign any_gen = |{br_l12, sl_l12, br_c2, sl_c2, br_l3, sl_l3, br_l4, sl_l4};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_cause == '0 && !out_src && !out_xfer)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req)) |->
        ($stable(out_valid) && $stable(out_cause) && $stable(out_src) && $stable(out_xfer))); // R2

    AST_FIRST_XFER_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req) && !$past(mode) && $past(xfer0_flt) != '0) |->
        (out_valid && !out_xfer && !out_src && out_cause[5:3] == 3'd0)); // R4

    AST_SECOND_XFER: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req) && !$past(mode) && $past(xfer0_flt) == '0 &&
         $past(xfer1_flt) != '0) |-> (out_valid && out_xfer)); // R9

    AST_BRANCH_L12_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req) && $past(mode) && $past(br_l12) != '0) |->
        (out_valid && !out_src && out_cause[5:3] == 3'd1)); // R5

    AST_NOTHING_PENDING: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req) && $past(xfer0_flt) == '0 && $past(xfer1_flt) == '0 &&
         !$past(any_gen)) |-> (!out_valid && out_cause == '0 && !out_src && !out_xfer)); // R8

    AST_XFER_ONLY_MEM: assert property (@(posedge clk) disable iff (rst)
        out_xfer |-> (out_valid && out_cause[5:3] == 3'd0)); // R9
endmodule

bind exc_prio_resolver exc_prio_resolver_chk #(.NGEN(NGEN)) u_chk (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .slot_two_xfer(slot_two_xfer),
    .xfer0_flt(xfer0_flt), .xfer1_flt(xfer1_flt),
    .br_l12(br_l12), .sl_l12(sl_l12), .br_c2(br_c2), .sl_c2(sl_c2),
    .br_l3(br_l3), .sl_l3(sl_l3), .br_l4(br_l4), .sl_l4(sl_l4),
    .out_valid(out_valid), .out_cause(out_cause), .out_src(out_src), .out_xfer(out_xfer)
);

// File: tb/exc_prio_resolver_bench.sv
module exc_prio_resolver_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       mode = 1'b0;
    logic       slot_two_xfer = 1'b0;
    logic [3:0] x0 = '0, x1 = '0;
    logic [3:0] g [8];
    logic       out_valid;
    logic [5:0] out_cause;
    logic       out_src, out_xfer;

    int vectors = 0;
    int misses  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    exc_prio_resolver #(.NGEN(4)) u_exc_prio_resolver (
        .clk(clk), .rst(rst), .req(req), .mode(mode), .slot_two_xfer(slot_two_xfer),
        .xfer0_flt(x0), .xfer1_flt(x1),
        .br_l12(g[0]), .sl_l12(g[1]), .br_c2(g[2]), .sl_c2(g[3]),
        .br_l3(g[4]), .sl_l3(g[5]), .br_l4(g[6]), .sl_l4(g[7]),
        .out_valid(out_valid), .out_cause(out_cause), .out_src(out_src), .out_xfer(out_xfer)
    );

    function automatic logic [2:0] low_idx(logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    // expected {valid, cause[5:0], src, xfer}
    function automatic logic [8:0] pack_res(int grp, logic [3:0] v, logic s, logic x);
        return {1'b1, 3'(grp), low_idx(v), s, x};
    endfunction

    function automatic logic [8:0] model();
        if (!mode) begin
            if (x0 != 0) return pack_res(0, x0, 1'b0, 1'b0);
            if (x1 != 0) return pack_res(0, x1, 1'b0, 1'b1);
            return 9'd0;
        end
        if (g[0] != 0) return pack_res(1, g[0], 1'b0, 1'b0);
        if (x0 != 0) return pack_res(0, x0, 1'b1, 1'b0);
        if (slot_two_xfer && x1 != 0) return pack_res(0, x1, 1'b1, 1'b1);
        if (g[1] != 0) return pack_res(1, g[1], 1'b1, 1'b0);
        for (int k = 2; k < 8; k++)
            if (g[k] != 0) return pack_res(1 + k / 2, g[k], 1'(k % 2), 1'b0);
        return 9'd0;
    endfunction

    task automatic check(string tag, logic [8:0] exp);
        logic [8:0] act;
        act = {out_valid, out_cause, out_src, out_xfer};
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got v=%0b c=%02h s=%0b x=%0b, expected v=%0b c=%02h s=%0b x=%0b",
                     tag, act[8], act[7:2], act[1], act[0], exp[8], exp[7:2], exp[1], exp[0]);
        end
    endtask

    task automatic clear_in();
        x0 = '0; x1 = '0;
        for (int k = 0; k < 8; k++) g[k] = '0;
    endtask

    task automatic apply(string tag);
        logic [8:0] exp;
        exp = model();
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(tag, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [8:0] held;
        clear_in();
        repeat (3) @(negedge clk);
        check("R1 reset", 9'd0);
        rst = 1'b0;
        @(negedge clk);

        // R8: no flag
        mode = 1'b0; apply("R8 two-transfer empty");
        mode = 1'b1; slot_two_xfer = 1'b1; apply("R8 pair empty");

        // R3: each single bit in each group
        for (int k = 0; k < 8; k++)
            for (int b = 0; b < 4; b++) begin
                clear_in(); mode = 1'b1; g[k] = 4'(1 << b);
                apply("R3 single flag");
            end
        for (int b = 0; b < 4; b++) begin
            clear_in(); mode = 1'b1; x0 = 4'(1 << b);
            apply("R3 memory fault bit");
        end

        // R6: level 3 and level 4 with both sources
        clear_in(); mode = 1'b1; g[4] = 4'b1000; g[5] = 4'b0001;
        apply("R6 level3 both");
        clear_in(); mode = 1'b1; g[6] = 4'b0100; g[7] = 4'b0010;
        apply("R6 level4 both");

        // R7: second transfer ignored without slot_two_xfer
        clear_in(); mode = 1'b1; slot_two_xfer = 1'b0; x1 = 4'b0010; g[1] = 4'b1000;
        apply("R7 xfer1 masked");
        clear_in(); x1 = 4'b0001;
        apply("R7 xfer1 only");

        // R4 / R9 sweep with noise on unused inputs; R2 hold after each
        mode = 1'b0;
        for (int a = 0; a < 256; a++) begin
            x0 = a[3:0]; x1 = a[7:4]; slot_two_xfer = a[0];
            for (int k = 0; k < 8; k++) g[k] = 4'(a * 3 + k);
            held = model();
            apply("R4,R9 two-transfer");
            x0 = ~x0; x1 = ~x1; mode = 1'b1;
            for (int k = 0; k < 8; k++) g[k] = ~g[k];
            @(negedge clk);
            check("R2 hold", held);
            mode = 1'b0;
        end

        // R5 sweep over every active-vector subset, both slot_two_xfer values
        mode = 1'b1;
        for (int m = 0; m < 1024; m++)
            for (int st = 0; st < 2; st++) begin
                slot_two_xfer = 1'(st);
                x0 = m[0] ? 4'(((m * 7 + 11) % 15) + 1) : 4'd0;
                x1 = m[1] ? 4'(((m * 7 + 13) % 15) + 1) : 4'd0;
                for (int k = 0; k < 8; k++)
                    g[k] = m[k + 2] ? 4'(((m * 7 + k * 5) % 15) + 1) : 4'd0;
                apply("R5,R6,R7 pair order");
            end

        // R1 mid-run reset
        clear_in(); mode = 1'b1; g[2] = 4'b0100;
        apply("R3 completion branch");
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset after result", 9'd0);
        rst = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule